// File: doc/BRIEF.md
# Page Write Buffer with Timed Program Cycle

This block sits behind the serial front end of a small serial nonvolatile memory. For a write instruction it collects the incoming data bytes in an eight-slot page buffer. The start address of the frame fixes the page, and the low address bits choose the first slot. Each accepted byte moves a three-bit slot pointer forward. The pointer wraps inside the page, so the page number never changes. If more than eight bytes arrive, the later bytes overwrite the earlier ones.

When chip select rises, the front end raises `cs_rise` for one cycle. It also reports on `cs_aligned` whether the rise came right after a complete byte, and protection control reports on `wr_permit` whether writing is allowed. A rise that is aligned and permitted, with at least one byte collected, starts the program cycle. Any other rise discards the frame and leaves the block idle. During the program cycle the block writes every slot that was filled, one per cycle, through the array write port. A busy timer of `WRITE_CYCLES` cycles stands in for the self-timed cycle. At the end, a one-cycle `done` pulse tells the write-enable logic to clear itself.

Bytes enter over a valid/ready stream. A byte is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole program cycle, so the sender must hold its byte until `in_ready` returns. The array write port has no back-pressure: the array takes every write it is given.

Top module: `pwb_page_writer`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0 and `in_ready` is 1.
- R2: The k-th accepted byte of a frame (counting from 0) is written to address {start_addr[6:3], (start_addr[2:0]+k) mod 8}. Bits [6:3] of the address never change within a frame.
- R3: When more than 8 bytes arrive in one frame, each slot holds the last byte sent to it.
- R4: Only the slots that received a byte are written. A frame that fills n slots makes exactly min(n,8) array writes, and every other array location keeps its contents.
- R5: A chip-select rise with `cs_aligned`=0 makes no array write and does not raise `busy`.
- R6: A chip-select rise with `wr_permit`=0 makes no array write and does not raise `busy`.
- R7: After an accepted commit, `busy` is 1 from the next cycle on, for exactly `WRITE_CYCLES` cycles. `done` is 1 for exactly one cycle: the first cycle in which `busy` is back at 0.
- R8: `in_ready` is 0 while `busy` is 1. Bytes, start strobes and chip-select rises offered during busy are ignored.
- R9: A chip-select rise after a frame that collected no bytes does not raise `busy` and makes no write.
- R10: `mem_we` is asserted only while `busy` is 1, writes go out in ascending slot order, and all of them fall within the first 8 busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start of a write frame; loads the start address and empties the buffer |
| start_addr | input | 7 | Frame start address (page in [6:3], slot in [2:0]) |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Data byte |
| cs_rise | input | 1 | One-cycle event: chip select went high |
| cs_aligned | input | 1 | The chip-select rise fell on a byte boundary |
| wr_permit | input | 1 | Writing is allowed by protection control |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| done | output | 1 | One-cycle pulse when the program cycle ends |

## Verification
The hardest case to reach from the ports is an overfilled, wrapped page: the start slot sits near the top of the page and more than eight bytes arrive. Only then does a slot get overwritten while the pointer also crosses the page boundary. The stimulus table includes a frame that starts at slot 3 and sends eleven bytes, and another that starts at the last slot of the last page. The bench records every array write in its own memory image. After all frames it compares the whole image with one predicted from the requirements. This also shows that rejected frames and untouched slots left their locations unchanged. A directed test offers bytes, start strobes and a chip-select rise during busy. It then shows that a later rise finds an empty buffer.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PWB_ADDR_W = 7;
  localparam int unsigned PWB_DATA_W = 8;
  localparam int unsigned PWB_PAGE   = 8;

  typedef enum logic [1:0] {
    FR_HOLD   = 2'd0,
    FR_COMMIT = 2'd1,
    FR_DROP   = 2'd2
  } frame_dec_e;
endpackage

// File: rtl/pwb_slot_store.sv
module pwb_slot_store #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 8,
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [OFS_W-1:0]      load_ofs,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  clear,
  input  logic [OFS_W-1:0]      rd_idx,
  output logic [DATA_W-1:0]     rd_data,
  output logic [PAGE_BYTES-1:0] filled,
  output logic [OFS_W-1:0]      ptr
);
  logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_flat;

  // Slot pointer: wraps inside the page by its width
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (load)   ptr <= load_ofs;
    else if (wr_en)  ptr <= ptr + 1'b1;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [DATA_W-1:0] d_q;
    logic              f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        f_q <= 1'b0;
      end else if (clear || load) begin
        f_q <= 1'b0;
      end else if (wr_en && ptr == OFS_W'(g)) begin
        d_q <= wr_data;
        f_q <= 1'b1;
      end
    end
    assign slot_flat[g] = d_q;
    assign filled[g]    = f_q;
  end

  assign rd_data = slot_flat[rd_idx];

  AST_FILL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !load && !clear) |=> $stable(filled)); // R4
endmodule

// File: rtl/pwb_commit_ctrl.sv
module pwb_commit_ctrl #(
  parameter int unsigned PAGE_BYTES   = 8,
  parameter int unsigned WRITE_CYCLES = 16,
  localparam int unsigned CNT_W  = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1,
  localparam int unsigned SCAN_W = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  output logic              busy,
  output logic              done,
  output logic              finish,
  output logic              scan_active,
  output logic [SCAN_W-1:0] scan_idx
);
  logic [CNT_W-1:0] cnt;

  assign finish      = busy && (cnt == '0);
  assign scan_active = busy && (scan_idx < SCAN_W'(PAGE_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      scan_idx <= '0;
    end else begin
      done <= 1'b0;
      if (commit && !busy) begin
        busy     <= 1'b1;
        cnt      <= CNT_W'(WRITE_CYCLES - 1);
        scan_idx <= '0;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        if (scan_idx != SCAN_W'(PAGE_BYTES)) scan_idx <= scan_idx + 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7
  AST_SCAN_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_active) |=> (!busy || !scan_active)); // R10
endmodule

// File: rtl/pwb_page_writer.sv
module pwb_page_writer
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W       = PWB_ADDR_W,
  parameter int unsigned DATA_W       = PWB_DATA_W,
  parameter int unsigned PAGE_BYTES   = PWB_PAGE,
  parameter int unsigned WRITE_CYCLES = 16,
  localparam int unsigned OFS_W  = $clog2(PAGE_BYTES),
  localparam int unsigned PG_W   = ADDR_W - OFS_W,
  localparam int unsigned SCAN_W = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wr_permit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done
);
  logic [PG_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0] filled;
  logic [OFS_W-1:0]      ptr;
  logic [SCAN_W-1:0]     scan_idx;
  logic                  scan_active, finish, commit, accept, load, clear;
  logic [DATA_W-1:0]     rd_data;
  frame_dec_e            dec;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign load     = start_valid && !busy;

  always_comb begin
    dec = FR_HOLD;
    if (cs_rise && !busy) begin
      if (cs_aligned && wr_permit && (|filled)) dec = FR_COMMIT;
      else                                       dec = FR_DROP;
    end
  end

  assign commit = (dec == FR_COMMIT);
  assign clear  = (dec == FR_DROP) || finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    page_q <= '0;
    else if (load) page_q <= start_addr[ADDR_W-1:OFS_W];
  end

  pwb_slot_store #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_ofs (start_addr[OFS_W-1:0]),
    .wr_en    (accept),
    .wr_data  (in_data),
    .clear    (clear),
    .rd_idx   (scan_idx[OFS_W-1:0]),
    .rd_data  (rd_data),
    .filled   (filled),
    .ptr      (ptr)
  );

  pwb_commit_ctrl #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .busy        (busy),
    .done        (done),
    .finish      (finish),
    .scan_active (scan_active),
    .scan_idx    (scan_idx)
  );

  assign mem_we    = scan_active && filled[scan_idx[OFS_W-1:0]];
  assign mem_addr  = {page_q, scan_idx[OFS_W-1:0]};
  assign mem_wdata = rd_data;

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R10
  AST_COMMIT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy); // R7
  AST_MISALIGNED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && !cs_aligned) |=> !busy); // R5
  AST_DENIED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && !wr_permit) |=> !busy); // R6
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !busy && filled == '0) |=> !busy); // R9
  AST_PTR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr)); // R8
  AST_PAGE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(page_q)); // R2
endmodule

// File: tb/test_pwb_page_writer.sv
module test_pwb_page_writer;
  localparam int CLK_PERIOD = 10;
  localparam int WCYC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_valid = 1'b0;
  logic [6:0] start_addr = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       cs_rise = 1'b0;
  logic       cs_aligned = 1'b0;
  logic       wr_permit = 1'b0;
  logic       mem_we;
  logic [6:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       busy;
  logic       done;

  int n_tests = 0;
  int n_fail  = 0;
  int wr_total = 0;
  logic [7:0] obs_mem [128];
  logic [7:0] exp_mem [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_page_writer #(.WRITE_CYCLES(WCYC)) i_pwb_page_writer (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cs_rise(cs_rise), .cs_aligned(cs_aligned), .wr_permit(wr_permit),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      obs_mem[mem_addr] <= mem_wdata;
      wr_total <= wr_total + 1;
    end
  end

  // {addr[20:14], nbytes[13:10], seed[9:2], aligned[1], permit[0]}
  localparam logic [20:0] VEC [8] = '{
    {7'h10, 4'd3,  8'h11, 1'b1, 1'b1},  // R2 basic
    {7'h1E, 4'd4,  8'h40, 1'b1, 1'b1},  // R2 wrap in page
    {7'h23, 4'd11, 8'h90, 1'b1, 1'b1},  // R3 overfill
    {7'h40, 4'd2,  8'h5A, 1'b0, 1'b1},  // R5 misaligned
    {7'h48, 4'd5,  8'hC3, 1'b1, 1'b0},  // R6 denied
    {7'h7F, 4'd8,  8'h01, 1'b1, 1'b1},  // R2 full page, last slot start
    {7'h05, 4'd1,  8'hA7, 1'b1, 1'b1},  // R4 single slot
    {7'h30, 4'd0,  8'h00, 1'b1, 1'b1}   // R9 no bytes
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [6:0] addr, input int nb, input logic [7:0] seed,
                           input bit aligned, input bit permit, input string tag);
    bit do_commit;
    int w0;
    int cyc;
    w0 = wr_total;
    do_commit = aligned && permit && (nb > 0);
    @(negedge clk);
    start_valid = 1'b1; start_addr = addr;
    @(negedge clk);
    start_valid = 1'b0;
    for (int i = 0; i < nb; i++) begin
      in_valid = 1'b1; in_data = seed + 8'(i * 7);
      if (do_commit) exp_mem[{addr[6:3], 3'(addr[2:0] + 3'(i))}] = in_data;
      @(negedge clk);
    end
    in_valid = 1'b0;
    cs_rise = 1'b1; cs_aligned = aligned; wr_permit = permit;
    @(negedge clk);
    cs_rise = 1'b0;
    check(busy == do_commit, {tag, " busy after cs rise"}, int'(busy), int'(do_commit));
    if (do_commit) begin
      check(in_ready == 1'b0, "R8 in_ready low while busy", int'(in_ready), 0);
      cyc = 0;
      while (busy === 1'b1 && cyc < 1000) begin
        cyc++;
        @(negedge clk);
      end
      check(cyc == WCYC, "R7 busy length", cyc, WCYC);
      check(done == 1'b1, "R7 done at busy fall", int'(done), 1);
      @(negedge clk);
      check(done == 1'b0, "R7 done single cycle", int'(done), 0);
    end else begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, {tag, " stays idle"}, int'(busy), 0);
    end
    check(wr_total - w0 == (do_commit ? ((nb > 8) ? 8 : nb) : 0),
          {tag, " R4 write count"}, wr_total - w0, do_commit ? ((nb > 8) ? 8 : nb) : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int mism;
    for (int a = 0; a < 128; a++) begin
      obs_mem[a] = 8'h00;
      exp_mem[a] = 8'h00;
    end
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && mem_we == 0 && in_ready == 1,
          "R1 reset outputs", int'({busy, done, mem_we, in_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && mem_we == 0 && in_ready == 1,
          "R1 after reset release", int'({busy, done, mem_we, in_ready}), 1);

    for (int v = 0; v < 8; v++) begin
      run_frame(VEC[v][20:14], int'(VEC[v][13:10]), VEC[v][9:2], VEC[v][1], VEC[v][0],
                $sformatf("vec%0d", v));
    end

    // R8: traffic during busy is ignored; a later rise finds an empty buffer (R9)
    @(negedge clk);
    start_valid = 1'b1; start_addr = 7'h60;
    @(negedge clk);
    start_valid = 1'b0;
    in_valid = 1'b1; in_data = 8'h3C; exp_mem[7'h60] = 8'h3C;
    @(negedge clk);
    in_valid = 1'b0; cs_rise = 1'b1; cs_aligned = 1'b1; wr_permit = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    check(busy == 1'b1, "R7 directed commit", int'(busy), 1);
    start_valid = 1'b1; start_addr = 7'h00; in_valid = 1'b1; in_data = 8'hEE;
    repeat (4) @(negedge clk);
    cs_rise = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0; start_valid = 1'b0;
    while (busy === 1'b1) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    cs_rise = 1'b1; cs_aligned = 1'b1; wr_permit = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    check(busy == 1'b0, "R8 busy-time bytes not taken (R9 empty rise)", int'(busy), 0);
    repeat (2) @(negedge clk);

    mism = 0;
    for (int a = 0; a < 128; a++) if (obs_mem[a] !== exp_mem[a]) mism++;
    check(mism == 0, "R2 R3 R4 array image", mism, 0);
    check(obs_mem[7'h23] == 8'h90 + 8'd56, "R3 overwritten slot", int'(obs_mem[7'h23]), int'(8'h90 + 8'd56));
    check(obs_mem[7'h18] == 8'h40 + 8'd14, "R2 wrapped byte stays in page", int'(obs_mem[7'h18]), int'(8'h40 + 8'd14));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule